// File: doc/BRIEF.md
# Condition Code Flag Unit

This block keeps the 8-bit condition code register of an accumulator CPU that works on both bytes and 16-bit words. For each operation the datapath presents two operands, the result it produced, an operation class and a size bit. When the update strobe is high, the block works out the sign, zero, overflow and carry flags from those values. It writes all of them into the register on one clock edge. The upper four bits (stop, extended interrupt mask, half carry, interrupt mask) are never changed by an operation update.

Carry and overflow come from bitwise equations on the sign positions of the operands and the result, so the block needs no adder of its own. A second path lets the control logic force any single register bit to 0 or 1. This path can fire in the same cycle as an operation update, and it then decides the value of its own bit.

Top module: `ccr_flag_unit`

## Requirements
- R1: After reset the register reads 0xD0. The bit order from bit 7 down to bit 0 is stop, extended mask, half carry, interrupt mask, N, Z, V, C.
- R2: The sign position is bit 7 when `wide` is 0 and bit 15 when `wide` is 1. N is set from that bit of `res`. Z is set only when every bit of `res` inside the selected size is zero. In byte mode the upper byte of every input is ignored.
- R3: With class code 0 (add), C is the sign bit of (a&b)|(b&~r)|(a&~r) and V is the sign bit of (a&b&~r)|(~a&~b&r). When `res` is the true sum, C equals the unsigned carry out and V equals signed overflow.
- R4: With class code 1 (subtract), C is the sign bit of (~a&b)|(b&r)|(~a&r) and V is the sign bit of (a&~b&~r)|(~a&b&r). When `res` is the true difference, C is the unsigned borrow and V is signed overflow.
- R5: With class code 2 (test/load), V is cleared, N and Z are updated and C keeps its old value.
- R6: With class code 3 (shift), C takes `sh_c`, N and Z are updated, and V becomes the new N XOR the new C.
- R7: An operation update never changes bits 7 to 4.
- R8: With `upd` and `fs_en` both low, the register holds its value whatever the other inputs are.
- R9: With `fs_en` high, bit `fs_idx` (0 to 7) takes `fs_val` and every other bit keeps its value.
- R10: When `upd` and `fs_en` are high in the same cycle, the operation update applies first and the single-bit write then overrides its own bit.
- R11: All flags of one operation become visible together, one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd | input | 1 | Operation update strobe |
| cls | input | 2 | Operation class: 0 add, 1 subtract, 2 test/load, 3 shift |
| wide | input | 1 | 1 for a 16-bit operation, 0 for an 8-bit operation |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| res | input | W | Result produced by the datapath |
| sh_c | input | 1 | Carry out produced by a shift |
| fs_en | input | 1 | Single-bit write strobe |
| fs_idx | input | 3 | Index of the bit to write |
| fs_val | input | 1 | Value written to the selected bit |
| ccr | output | 8 | Condition code register |

## Verification
An operation update and a single-bit write can both land in the same cycle. The bench provokes this in two ways. In the first, the forced bit is a flag the operation also computes (the forced value must win). In the second, the forced bit is an upper bit (all arithmetic flags must still come from the operation). A scoreboard model applies the operation before the write. It compares the whole register one cycle later, so a wrong priority or a dropped flag shows up as a mismatch.

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit #(
  parameter int         W       = 16,
  parameter logic [7:0] RST_CCR = 8'hD0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [1:0]   cls,
  input  logic         wide,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] res,
  input  logic         sh_c,
  input  logic         fs_en,
  input  logic [2:0]   fs_idx,
  input  logic         fs_val,
  output logic [7:0]   ccr
);
  localparam int HB = W / 2;
  localparam int BC = 0;
  localparam int BV = 1;
  localparam int BZ = 2;
  localparam int BN = 3;

  logic [W-1:0] add_cv, add_ov, sub_cv, sub_ov;
  logic         n_f, z_f;
  logic [7:0]   ccr_op, ccr_nx;

  function automatic logic sgn(input logic [W-1:0] x, input logic wd);
    return wd ? x[W-1] : x[HB-1];
  endfunction

  assign add_cv = (opa & opb) | (opb & ~res) | (opa & ~res);
  assign add_ov = (opa & opb & ~res) | (~opa & ~opb & res);
  assign sub_cv = (~opa & opb) | (opb & res) | (~opa & res);
  assign sub_ov = (opa & ~opb & ~res) | (~opa & opb & res);

  assign n_f = sgn(res, wide);
  assign z_f = wide ? (res == '0) : (res[HB-1:0] == '0);

  always_comb begin
    ccr_op = ccr;
    if (upd) begin
      ccr_op[BN] = n_f;
      ccr_op[BZ] = z_f;
      case (cls)
        2'd0: begin
          ccr_op[BC] = sgn(add_cv, wide);
          ccr_op[BV] = sgn(add_ov, wide);
        end
        2'd1: begin
          ccr_op[BC] = sgn(sub_cv, wide);
          ccr_op[BV] = sgn(sub_ov, wide);
        end
        2'd2: ccr_op[BV] = 1'b0;
        default: begin
          ccr_op[BC] = sh_c;
          ccr_op[BV] = n_f ^ sh_c;
        end
      endcase
    end
    ccr_nx = ccr_op;
    if (fs_en) ccr_nx[fs_idx] = fs_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ccr <= RST_CCR;
    else        ccr <= ccr_nx;
  end
endmodule

// File: rtl/ccr_flag_unit_chk.sv
module ccr_flag_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         upd,
  input logic [1:0]   cls,
  input logic         wide,
  input logic [W-1:0] res,
  input logic         fs_en,
  input logic [2:0]   fs_idx,
  input logic         fs_val,
  input logic [7:0]   ccr
);
  logic zchk;
  assign zchk = wide ? (res == '0) : (res[W/2-1:0] == '0);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !fs_en) |=> $stable(ccr)); // R8
  AST_SYS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !fs_en) |=> ccr[7:4] == $past(ccr[7:4])); // R7
  AST_TST_V: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cls == 2'd2 && !fs_en) |=> (!ccr[1] && ccr[0] == $past(ccr[0]))); // R5
  AST_SHF_V: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cls == 2'd3 && !fs_en) |=> ccr[1] == (ccr[3] ^ ccr[0])); // R6
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fs_en |=> ccr[$past(fs_idx)] == $past(fs_val)); // R9
  AST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !fs_en) |=> ccr[2] == $past(zchk)); // R2
endmodule

bind ccr_flag_unit ccr_flag_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .cls(cls), .wide(wide), .res(res),
  .fs_en(fs_en), .fs_idx(fs_idx), .fs_val(fs_val), .ccr(ccr)
);

// File: tb/ccr_flag_unit_tb.sv
module ccr_flag_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        upd = 0;
  logic [1:0]  cls = 0;
  logic        wide = 0;
  logic [15:0] opa = 0, opb = 0, res = 0;
  logic        sh_c = 0;
  logic        fs_en = 0;
  logic [2:0]  fs_idx = 0;
  logic        fs_val = 0;
  logic [7:0]  ccr;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] model = 8'hD0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #4 clk = ~clk;

  ccr_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .upd(upd), .cls(cls), .wide(wide),
    .opa(opa), .opb(opb), .res(res), .sh_c(sh_c), .fs_en(fs_en),
    .fs_idx(fs_idx), .fs_val(fs_val), .ccr(ccr)
  );

  function automatic logic [7:0] step_model(
    logic [7:0] cur, logic u, logic [1:0] c, logic wd,
    logic [15:0] a, logic [15:0] b, logic [15:0] r, logic shc,
    logic fe, logic [2:0] fi, logic fv);
    logic [7:0] nx = cur;
    int unsigned ma, mb, lim;
    logic sa, sb, sr, zz;
    ma = wd ? a : a[7:0];
    mb = wd ? b : b[7:0];
    lim = wd ? 65535 : 255;
    sa = wd ? a[15] : a[7];
    sb = wd ? b[15] : b[7];
    sr = wd ? r[15] : r[7];
    zz = wd ? (r == 0) : (r[7:0] == 0);
    if (u) begin
      nx[3] = sr;
      nx[2] = zz;
      case (c)
        2'd0: begin nx[0] = (ma + mb) > lim; nx[1] = (sa == sb) && (sr != sa); end
        2'd1: begin nx[0] = ma < mb;         nx[1] = (sa != sb) && (sr != sa); end
        2'd2: nx[1] = 1'b0;
        default: begin nx[0] = shc; nx[1] = sr ^ shc; end
      endcase
    end
    if (fe) nx[fi] = fv;
    return nx;
  endfunction

  task automatic drive(logic u, logic [1:0] c, logic wd, logic [15:0] a,
                       logic [15:0] b, logic [15:0] r, logic shc, logic fe,
                       logic [2:0] fi, logic fv, string tag);
    @(negedge clk);
    upd = u; cls = c; wide = wd; opa = a; opb = b; res = r; sh_c = shc;
    fs_en = fe; fs_idx = fi; fs_val = fv;
    model = step_model(model, u, c, wd, a, b, r, shc, fe, fi, fv);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic add_op(logic wd, logic [15:0] a, logic [15:0] b, string tag);
    drive(1, 2'd0, wd, a, b, a + b, 0, 0, 0, 0, tag);
  endtask

  task automatic sub_op(logic wd, logic [15:0] a, logic [15:0] b, string tag);
    drive(1, 2'd1, wd, a, b, a - b, 0, 0, 0, 0, tag);
  endtask

  task automatic setbit(logic [2:0] i, logic v, string tag);
    drive(0, 0, 0, 16'h1234, 16'h5678, 16'h9ABC, 1, 1, i, v, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (ccr !== e) begin
        n_bad++;
        $display("FAIL %s: ccr=%02h expected=%02h", t, ccr, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (ccr !== 8'hD0) begin
      n_bad++;
      $display("FAIL R1: reset ccr=%02h expected=d0", ccr);
    end
    rst_n = 1;
    // R2 R3: byte add with garbage upper bytes, overflow to negative
    drive(1, 2'd0, 0, 16'hA57F, 16'h3C01, 16'h0080, 0, 0, 0, 0, "R3 byte add V/N");
    add_op(0, 16'h00FF, 16'h0001, "R3 byte add C/Z");
    add_op(1, 16'h7FFF, 16'h0001, "R3 word add V");
    add_op(1, 16'hFFFF, 16'h0001, "R3 word add C/Z");
    add_op(1, 16'h1234, 16'h0101, "R11 word add plain");
    // R4 subtract
    sub_op(0, 16'h0000, 16'h0001, "R4 byte sub borrow");
    sub_op(0, 16'h0080, 16'h0001, "R4 byte sub V");
    sub_op(1, 16'h8000, 16'h0001, "R4 word sub V");
    sub_op(1, 16'h4444, 16'h4444, "R4 word sub Z");
    // R2: byte zero with nonzero upper byte
    drive(1, 2'd2, 0, 16'h0, 16'h0, 16'hFF00, 0, 0, 0, 0, "R2 byte Z ignores upper");
    drive(1, 2'd2, 1, 16'h0, 16'h0, 16'hFF00, 0, 0, 0, 0, "R2 word N");
    // R5: test keeps C, clears V
    setbit(3'd0, 1, "R9 set C");
    setbit(3'd1, 1, "R9 set V");
    drive(1, 2'd2, 0, 16'h0, 16'h0, 16'h0042, 0, 0, 0, 0, "R5 tst keep C clear V");
    // R6 shift
    drive(1, 2'd3, 0, 16'h0, 16'h0, 16'h0081, 0, 0, 0, 0, "R6 shift N=1 C=0");
    drive(1, 2'd3, 0, 16'h0, 16'h0, 16'h0081, 1, 0, 0, 0, "R6 shift N=1 C=1");
    drive(1, 2'd3, 1, 16'h0, 16'h0, 16'h0000, 1, 0, 0, 0, "R6 shift Z C=1");
    // R7: set H, then ops must keep upper nibble
    setbit(3'd5, 1, "R9 set H");
    setbit(3'd7, 0, "R9 clear S");
    add_op(0, 16'h0050, 16'h0050, "R7 add keeps upper");
    sub_op(1, 16'h0001, 16'h0002, "R7 sub keeps upper");
    // R8 idle with garbage
    drive(0, 2'd1, 1, 16'hFFFF, 16'h0001, 16'h0000, 1, 0, 3'd2, 1, "R8 idle hold");
    drive(0, 2'd3, 0, 16'h0000, 16'h0000, 16'h0000, 0, 0, 3'd0, 0, "R8 idle hold 2");
    // R10 same-cycle: forced bit is one the op computes
    drive(1, 2'd0, 0, 16'h00FF, 16'h0001, 16'h0100, 0, 1, 3'd2, 0, "R10 op+force Z");
    // R10 same-cycle: forced upper bit, flags from op
    drive(1, 2'd1, 1, 16'h0000, 16'h0001, 16'hFFFF, 0, 1, 3'd4, 0, "R10 op+force I");
    setbit(3'd6, 0, "R9 clear X");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 final idle");
    @(negedge clk);
    upd = 0; fs_en = 0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule